// File: doc/BRIEF.md
# Two-Stage Boot Instruction Memory with Bank Swap

This block serves instruction and data words to a soft processor that boots in two stages. It holds two on-chip banks. The boot bank is a fixed, pre-initialised image that behaves as a ROM. The load bank is a dual-port RAM. After a full device reset the boot bank answers at the processor's reset vector (word address 0). Boot code reads the production image from external flash and streams it into the load bank. It does this through a pointer register and a data register, and it may also store words directly into the load bank's window.

When the boot code writes a fixed key to the swap register, the block inverts the bank-select address bit, so the load bank now answers at the reset vector. One cycle later the block drives a processor-only reset pulse of fixed length. The processor then restarts from the loaded image while the rest of the device keeps its configuration. The swap state survives that pulse and is cleared only by the full device reset. A second bus master can read the load bank at any time through the RAM's second port.

Top module: `boot_swap_mem`

## Requirements
- R1: After `rst_n` is released, `cpu_rst_o` is low, `cpu_rdata_o` is 0 and word address 0 returns boot bank word 0.
- R2: Boot bank word i reads as 0xB0070000 + i. Processor writes that map to the boot bank are ignored at all times.
- R3: With address bit 7 set, address bits 1:0 pick a register. 0 is the load pointer: a write sets it from wdata[5:0] and a read returns it. 1 is load data: a write stores wdata at the pointer and then increments the pointer modulo 64. 2 is the swap key. 3 is status, where bit 0 is 1 when the load bank is at the reset vector and bit 1 is 1 while a reset pulse is pending or active. Other read bits are 0.
- R4: With address bit 7 clear, bit 6 XOR the swap state selects the physical bank (0 boot, 1 load) and bits 5:0 give the word. A write that maps to the load bank is stored there.
- R5: Writing 0xA5C30F1E to the swap register sets the swap state on that clock edge. Writing any other value changes nothing.
- R6: The swap state is cleared only by `rst_n`. A key write while swapped causes no change and no new pulse.
- R7: `cpu_rst_o` rises one cycle after the swap state is set and stays high for exactly 16 cycles.
- R8: Processor requests made while `cpu_rst_o` is high are ignored: no write takes effect and `cpu_rdata_o` is unchanged.
- R9: `aux_rdata_o` returns the load bank word at `aux_addr_i` one cycle later. When the same word is written in the same cycle, it returns the value from before the write.
- R10: An accepted read updates `cpu_rdata_o` one cycle later, and `cpu_rdata_o` holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full device reset, active low |
| cpu_req_i | input | 1 | Processor access request |
| cpu_we_i | input | 1 | Processor write (1) or read (0) |
| cpu_addr_i | input | 8 | Processor word address |
| cpu_wdata_i | input | 32 | Processor write data |
| cpu_rdata_o | output | 32 | Processor read data, one cycle latency |
| cpu_rst_o | output | 1 | Processor-only reset pulse |
| aux_addr_i | input | 6 | Second master load bank word address |
| aux_rdata_o | output | 32 | Second master read data, one cycle latency |

## Verification
The assertions assume that processor inputs are driven to known values whenever `rst_n` is high, and that `cpu_req_i` is low during the full reset. The stimulus holds these conditions: inputs change only on the falling edge and the request is parked low around each reset. The bench first fills the whole load bank through the data register, so no read, including the second-port read, returns an unwritten word. It then issues requests during the reset pulse on purpose, so the ignore rule is tested rather than assumed.

// File: rtl/boot_swap_pkg.sv
package boot_swap_pkg;

    typedef enum logic [1:0] {
        SRC_ROM = 2'd0,
        SRC_RAM = 2'd1,
        SRC_REG = 2'd2
    } rd_src_e;

    localparam logic [1:0] REG_PTR    = 2'd0;
    localparam logic [1:0] REG_DATA   = 2'd1;
    localparam logic [1:0] REG_KEY    = 2'd2;
    localparam logic [1:0] REG_STATUS = 2'd3;

    localparam logic [31:0] BOOT_BASE = 32'hB007_0000;

    function automatic logic [31:0] boot_word(input int unsigned idx);
        return BOOT_BASE + 32'(idx);
    endfunction

endpackage

// File: rtl/boot_rom.sv
module boot_rom #(
    parameter int OFS_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [DATA_W-1:0] word_o
);
    import boot_swap_pkg::*;

    always_comb begin
        word_o = DATA_W'(boot_word(int'(ofs_i)));
    end

endmodule

// File: rtl/load_ram.sv
module load_ram #(
    parameter int OFS_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              a_en_i,
    input  logic              a_we_i,
    input  logic [OFS_W-1:0]  a_addr_i,
    input  logic [DATA_W-1:0] a_wdata_i,
    output logic [DATA_W-1:0] a_rdata_o,
    input  logic [OFS_W-1:0]  b_addr_i,
    output logic [DATA_W-1:0] b_rdata_o
);
    localparam int DEPTH = 1 << OFS_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_en_i && a_we_i) begin
            mem[a_addr_i] <= a_wdata_i;
        end
        if (a_en_i && !a_we_i) begin
            a_rdata_o <= mem[a_addr_i];
        end
        b_rdata_o <= mem[b_addr_i];
    end

endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl #(
    parameter int              DATA_W    = 32,
    parameter int              PULSE_LEN = 16,
    parameter logic [DATA_W-1:0] SWAP_KEY = 32'hA5C3_0F1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_i,
    output logic              swapped_o,
    output logic              pending_o,
    output logic              cpu_rst_o
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic             swapped;
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            st_d.pend = 1'b0;
            st_d.cnt  = CNT_W'(PULSE_LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (key_wr_i && (key_i == SWAP_KEY) && !st_q.swapped) begin
            st_d.swapped = 1'b1;
            st_d.pend    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign swapped_o = st_q.swapped;
    assign pending_o = st_q.pend || (st_q.cnt != '0);
    assign cpu_rst_o = (st_q.cnt != '0);

    // Checker counter: cycles the pulse has been high so far
    logic [CNT_W:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (cpu_rst_o) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end else begin
            hi_cnt_q <= '0;
        end
    end

    assert_swap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swapped_o |=> swapped_o);

    assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr_i && key_i != SWAP_KEY && !swapped_o) |=> !swapped_o);

    assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swapped_o) |=> $rose(cpu_rst_o));

    assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst_o) |-> (hi_cnt_q == (CNT_W+1)'(PULSE_LEN)));

endmodule

// File: rtl/boot_swap_mem.sv
module boot_swap_mem #(
    parameter int              OFS_W     = 6,
    parameter int              DATA_W    = 32,
    parameter int              PULSE_LEN = 16,
    parameter logic [DATA_W-1:0] SWAP_KEY = 32'hA5C3_0F1E,
    localparam int             ADDR_W    = OFS_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              cpu_rst_o,
    input  logic [OFS_W-1:0]  aux_addr_i,
    output logic [DATA_W-1:0] aux_rdata_o
);
    import boot_swap_pkg::*;

    localparam int REG_BIT  = ADDR_W - 1;
    localparam int BANK_BIT = OFS_W;

    typedef struct packed {
        logic [OFS_W-1:0]  ld_ptr;
        rd_src_e           src;
        logic [DATA_W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    logic              swapped, pending, pulse;
    logic              acc, is_reg, phys_load;
    logic [OFS_W-1:0]  ofs;
    logic [1:0]        rsel;
    logic              ram_en, ram_we;
    logic [OFS_W-1:0]  ram_addr;
    logic [DATA_W-1:0] ram_wdata, ram_rdata, rom_word;
    logic              key_wr;

    boot_rom #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rom (
        .ofs_i  (ofs),
        .word_o (rom_word)
    );

    load_ram #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_ram (
        .clk       (clk),
        .a_en_i    (ram_en),
        .a_we_i    (ram_we),
        .a_addr_i  (ram_addr),
        .a_wdata_i (ram_wdata),
        .a_rdata_o (ram_rdata),
        .b_addr_i  (aux_addr_i),
        .b_rdata_o (aux_rdata_o)
    );

    swap_ctrl #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN), .SWAP_KEY(SWAP_KEY)) u_swap (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr_i  (key_wr),
        .key_i     (cpu_wdata_i),
        .swapped_o (swapped),
        .pending_o (pending),
        .cpu_rst_o (pulse)
    );

    always_comb begin
        acc       = cpu_req_i && !pulse;
        is_reg    = cpu_addr_i[REG_BIT];
        phys_load = cpu_addr_i[BANK_BIT] ^ swapped;
        ofs       = cpu_addr_i[OFS_W-1:0];
        rsel      = cpu_addr_i[1:0];

        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = ofs;
        ram_wdata = cpu_wdata_i;
        key_wr    = 1'b0;
        st_d      = st_q;

        if (acc && !is_reg && phys_load) begin
            ram_en = 1'b1;
            ram_we = cpu_we_i;
        end

        if (acc && is_reg && cpu_we_i) begin
            unique case (rsel)
                REG_PTR:  st_d.ld_ptr = cpu_wdata_i[OFS_W-1:0];
                REG_DATA: begin
                    ram_en      = 1'b1;
                    ram_we      = 1'b1;
                    ram_addr    = st_q.ld_ptr;
                    st_d.ld_ptr = st_q.ld_ptr + 1'b1;
                end
                REG_KEY:  key_wr = 1'b1;
                default:  ;
            endcase
        end

        if (acc && !cpu_we_i) begin
            if (is_reg) begin
                st_d.src = SRC_REG;
                unique case (rsel)
                    REG_PTR:    st_d.word = DATA_W'(st_q.ld_ptr);
                    REG_STATUS: st_d.word = DATA_W'({pending, swapped});
                    default:    st_d.word = '0;
                endcase
            end else if (phys_load) begin
                st_d.src = SRC_RAM;
            end else begin
                st_d.src  = SRC_ROM;
                st_d.word = rom_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ld_ptr: '0, src: SRC_REG, word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rdata_o = (st_q.src == SRC_RAM) ? ram_rdata : st_q.word;
    assign cpu_rst_o   = pulse;

    assert_ignore_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_o |-> !ram_en && !key_wr);

    assert_hold_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_o |=> $stable(cpu_rdata_o));

    assert_boot_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && !cpu_we_i && !cpu_rst_o && !is_reg && !phys_load)
        |=> cpu_rdata_o == DATA_W'(boot_word(int'($past(ofs)))));

    assert_reset_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !is_reg && cpu_we_i && !phys_load) |-> !ram_en);

endmodule

// File: tb/sim_boot_swap_mem.sv
module sim_boot_swap_mem;

    localparam logic [31:0] KEY = 32'hA5C3_0F1E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [5:0]  aux_addr = '0;
    logic [31:0] rdata, aux_rdata;
    logic        cpu_rst;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    boot_swap_mem u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req_i   (req),
        .cpu_we_i    (we),
        .cpu_addr_i  (addr),
        .cpu_wdata_i (wdata),
        .cpu_rdata_o (rdata),
        .cpu_rst_o   (cpu_rst),
        .aux_addr_i  (aux_addr),
        .aux_rdata_o (aux_rdata)
    );

    // Reference model state
    logic [31:0] m_mem [64];
    bit          m_known [64];
    bit          m_swap, m_pend;
    int          m_cnt;
    logic [5:0]  m_ptr;
    logic [31:0] m_rdata, m_aux;
    bit          m_aux_known;

    function automatic logic [31:0] rom(input int i);
        return 32'hB007_0000 + 32'(i);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_swap = 0; m_pend = 0; m_cnt = 0; m_ptr = '0; m_rdata = '0; m_aux_known = 0;
    endtask

    task automatic full_reset();
        req = 0; we = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1;
        @(negedge clk);
        check("R1 rst_o after reset", {31'b0, cpu_rst}, 32'd0);
        check("R1 rdata after reset", rdata, 32'd0);
    endtask

    // One bus cycle: drive at falling edge, model at rising, compare at next falling edge
    task automatic cyc(input bit rq, input bit w, input logic [7:0] a,
                       input logic [31:0] d, input logic [5:0] ax, input string tag);
        bit busy, acc, isreg, ph, new_swap;
        logic [5:0] o;
        req = rq; we = w; addr = a; wdata = d; aux_addr = ax;
        @(posedge clk);
        #1;
        busy  = (m_cnt > 0);
        acc   = rq && !busy;
        isreg = a[7];
        ph    = a[6] ^ m_swap;
        o     = a[5:0];
        new_swap = 0;
        m_aux = m_mem[ax];
        m_aux_known = m_known[ax];
        if (acc && !w) begin
            if (isreg) begin
                case (a[1:0])
                    2'd0: m_rdata = {26'b0, m_ptr};
                    2'd3: m_rdata = {30'b0, (m_pend || m_cnt > 0), m_swap};
                    default: m_rdata = '0;
                endcase
            end else if (ph) m_rdata = m_mem[o];
            else m_rdata = rom(int'(o));
        end
        if (acc && w) begin
            if (isreg) begin
                case (a[1:0])
                    2'd0: m_ptr = d[5:0];
                    2'd1: begin m_mem[m_ptr] = d; m_known[m_ptr] = 1; m_ptr = m_ptr + 1; end
                    2'd2: if (d == KEY && !m_swap) new_swap = 1;
                    default: ;
                endcase
            end else if (ph) begin
                m_mem[o] = d; m_known[o] = 1;
            end
        end
        if (m_pend) begin m_cnt = 16; m_pend = 0; end
        else if (m_cnt > 0) m_cnt--;
        if (new_swap) begin m_swap = 1; m_pend = 1; end
        @(negedge clk);
        check({tag, " cpu_rst_o"}, {31'b0, cpu_rst}, {31'b0, (m_cnt > 0)});
        check({tag, " cpu_rdata_o"}, rdata, m_rdata);
        if (m_aux_known) check({tag, " aux_rdata_o (R9)"}, aux_rdata, m_aux);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_known[i] = 0; m_mem[i] = '0; end
        full_reset();

        // R1/R2: reset vector serves the boot bank
        cyc(1, 0, 8'h00, 0, 0, "R1 read vector");
        cyc(1, 0, 8'h05, 0, 0, "R2 boot word 5");
        cyc(1, 0, 8'h3F, 0, 0, "R2 boot word 63");
        cyc(1, 0, 8'h83, 0, 0, "R3 status at start");
        // R2: write to boot bank ignored
        cyc(1, 1, 8'h05, 32'hDEAD_BEEF, 0, "R2 boot write");
        cyc(1, 0, 8'h05, 0, 0, "R2 boot after write");
        cyc(0, 0, 8'h00, 0, 0, "R10 idle hold");

        // R3: fill the load bank through the data port
        cyc(1, 1, 8'h80, 32'h0, 0, "R3 set pointer");
        for (int i = 0; i < 64; i++)
            cyc(1, 1, 8'h81, (32'h0101_0101 * i) ^ 32'hC0DE, 6'(i), "R3 data fill");
        cyc(1, 0, 8'h80, 0, 6'd3, "R3 pointer wrapped");
        cyc(1, 1, 8'h80, 32'h0000_0FF2, 6'd50, "R3 pointer high bits dropped");
        cyc(1, 0, 8'h80, 0, 6'd50, "R3 pointer readback");
        cyc(1, 1, 8'h81, 32'h1234_5678, 6'd50, "R9 aux old value");
        cyc(1, 0, 8'h72, 0, 6'd50, "R4 read load bank 50");

        // R4: direct load-bank window
        cyc(1, 1, 8'h47, 32'hCAFE_0007, 6'd7, "R9 aux same-cycle write");
        cyc(1, 0, 8'h47, 0, 6'd7, "R4 direct readback");
        cyc(1, 0, 8'h40, 0, 6'd9, "R4 load word 0 before swap");

        // R5: wrong keys
        cyc(1, 1, 8'h82, KEY ^ 32'h1, 0, "R5 wrong key");
        cyc(1, 1, 8'h82, 32'h0, 0, "R5 zero key");
        cyc(1, 0, 8'h83, 0, 0, "R5 status unchanged");
        cyc(1, 0, 8'h00, 0, 0, "R5 vector unchanged");

        // R7: correct key, pulse, requests during pulse (R8)
        cyc(1, 1, 8'h82, KEY, 0, "R5 key accepted");
        cyc(1, 0, 8'h83, 0, 0, "R3 status pending");
        cyc(1, 1, 8'h00, 32'hBAD0_0000, 0, "R8 write in pulse");
        cyc(1, 1, 8'h81, 32'hBAD0_0001, 0, "R8 data write in pulse");
        cyc(1, 1, 8'h80, 32'h0, 0, "R8 pointer write in pulse");
        cyc(1, 0, 8'h40, 0, 0, "R8 read in pulse");
        for (int i = 0; i < 14; i++) cyc(0, 0, 8'h00, 0, 6'd0, "R7 pulse");
        cyc(0, 0, 8'h00, 0, 6'd0, "R7 pulse end");

        // R4/R6: after swap
        cyc(1, 0, 8'h00, 0, 0, "R4 vector now load bank");
        cyc(1, 0, 8'h40, 0, 0, "R4 boot bank moved up");
        cyc(1, 0, 8'h83, 0, 0, "R3 status swapped");
        cyc(1, 0, 8'h80, 0, 0, "R8 pointer kept");
        cyc(1, 1, 8'h41, 32'hBAD0_0002, 0, "R2 boot write after swap");
        cyc(1, 0, 8'h41, 0, 0, "R2 boot intact after swap");
        cyc(1, 1, 8'h82, KEY, 0, "R6 repeat key");
        for (int i = 0; i < 4; i++) cyc(0, 0, 8'h00, 0, 0, "R6 no second pulse");
        cyc(1, 0, 8'h83, 0, 0, "R6 status still swapped");

        // R6: full reset clears swap
        full_reset();
        cyc(1, 0, 8'h00, 0, 0, "R6 vector boot after full reset");
        cyc(1, 0, 8'h83, 0, 0, "R6 status cleared");
        cyc(1, 0, 8'h47, 0, 6'd7, "R4 load bank kept over reset");

        finish_run();
    end

endmodule